// File: doc/BRIEF.md
# SPI Serial Memory Command Engine

This block is the device side of a byte-addressed non-volatile memory reached over a mode-0 SPI bus. The bus pins are oversampled in the system clock domain. Once chip select falls, the first byte is decoded as an instruction. Array accesses then take a three-byte address and stream data bytes to or from an internal register array with no page buffering. Every completed byte is committed at once. The internal pointer steps by one per byte and wraps from the top of the array to zero. A hold input freezes a transfer mid-byte and later resumes it at the same bit.

Modifying instructions are gated by a write-enable latch. The latch is set by an explicit enable instruction and is dropped when chip select rises after any array-write or status-write instruction. An external protection unit is queried with the current pointer before each byte store. The same unit owns the protection bits of the status byte: it receives status writes and supplies the upper status bits for status reads.

Top module: `spi_mem_engine`

## Requirements
- R1: The instruction is the first byte after chip select falls, sampled MSB first on rising serial-clock edges. Codes: 0x06 enable writes, 0x04 disable writes, 0x05 read status, 0x01 write status, 0x03 read array, 0x02 write array. Any other code makes the rest of the selection ignored: the latch is unchanged, the array is unchanged and MISO stays disabled.
- R2: Array instructions take three address bytes, most significant first. Only the low MEM_AW bits of the 24 received bits select the byte.
- R3: A write-array or write-status instruction issued while the latch is clear has no effect. Instruction 0x06 sets the latch. Instruction 0x04 clears it.
- R4: When chip select rises after an accepted write-array or write-status instruction, the latch is cleared. This holds even when no data byte was sent.
- R5: During an accepted array write, each data byte is stored when its eighth bit arrives, and the pointer then advances by one.
- R6: During an array read, bytes are sent MSB first from consecutive addresses. MISO changes only after falling serial-clock edges, so its value is the same before a rising edge and before the following falling edge.
- R7: After address 2^MEM_AW-1 the pointer wraps to 0 and streaming continues, for reads and writes alike.
- R8: When hold goes low while the serial clock is low, the transfer freezes and MISO is disabled. Clock edges during hold are ignored. When hold goes high again while the clock is low, the transfer resumes at the same bit.
- R9: Raising chip select in the middle of a byte discards that byte. Nothing is stored for it.
- R10: The MISO enable is asserted only while array-read or status-read data is being shifted out. It is low during the instruction and address bytes, during writes and while deselected.
- R11: Before each byte store, the current address is presented on prot_addr. If prot_wr_ok is low, the byte is dropped and the pointer still advances.
- R12: A status read returns stat_rd_hi in bits 7..2, the latch in bit 1 and 0 in bit 0. The byte repeats for as long as clocks continue.
- R13: An accepted status write raises stat_wr_en for one clock, with the first data byte on stat_wr_data. Later bytes in the same selection are ignored.
- R14: After reset the latch is clear, the array holds zeros, MISO is disabled and stat_wr_en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock, mode 0 |
| spi_mosi | input | 1 | Serial data from the host |
| spi_hold_n | input | 1 | Pause request, active low |
| spi_miso | output | 1 | Serial data to the host |
| spi_miso_oe | output | 1 | Output enable for spi_miso |
| prot_addr | output | MEM_AW | Address being asked about for a store |
| prot_wr_ok | input | 1 | Protection unit permits a store at prot_addr |
| stat_rd_hi | input | 6 | Upper status bits from the protection unit |
| stat_wr_data | output | 8 | Byte delivered by a status write |
| stat_wr_en | output | 1 | One-clock strobe for stat_wr_data |

## Verification
The hardest situation to reach from the ports is a hold that lands in the middle of a byte with the clock still toggling, both while a write is being shifted in and while a read is being shifted out. The stimulus gets there by stopping after a few bits with the clock low, lowering hold, and running clock pulses with inverted MOSI. It then releases hold and finishes the byte. The byte that lands in the array, or arrives on MISO, must match the undisturbed value. Wrap-around is reached by a burst of 2^MEM_AW+2 bytes starting two below the top, followed by two-byte reads from every start address.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;

    typedef enum logic [2:0] {
        ST_CMD   = 3'd0,
        ST_ADDR  = 3'd1,
        ST_WDATA = 3'd2,
        ST_RDATA = 3'd3,
        ST_RSTAT = 3'd4,
        ST_WSTAT = 3'd5,
        ST_SKIP  = 3'd6
    } phase_e;

    localparam logic [7:0] OP_WR_EN   = 8'h06;
    localparam logic [7:0] OP_WR_DIS  = 8'h04;
    localparam logic [7:0] OP_RD_STAT = 8'h05;
    localparam logic [7:0] OP_WR_STAT = 8'h01;
    localparam logic [7:0] OP_RD_ARR  = 8'h03;
    localparam logic [7:0] OP_WR_ARR  = 8'h02;

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
    parameter int             W       = 4,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] pipe_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    pipe_q[s] <= RST_VAL;
                end else if (s == 0) begin
                    pipe_q[s] <= din;
                end else begin
                    pipe_q[s] <= pipe_q[(s == 0) ? 0 : s - 1];
                end
            end
        end
    endgenerate

    assign dout = pipe_q[STAGES-1];

endmodule

// File: rtl/spi_mem_array.sv
module spi_mem_array #(
    parameter int AW = 5,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cell_q [DEPTH];

    genvar i;
    generate
        for (i = 0; i < DEPTH; i++) begin : g_cell
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cell_q[i] <= '0;
                end else if (we && (waddr == AW'(i))) begin
                    cell_q[i] <= wdata;
                end
            end
        end
    endgenerate

    assign rdata = cell_q[raddr];

endmodule

// File: rtl/spi_mem_engine.sv
module spi_mem_engine
    import spi_mem_pkg::*;
#(
    parameter int MEM_AW      = 5,
    parameter int ADDR_BYTES  = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_cs_n,
    input  logic              spi_sck,
    input  logic              spi_mosi,
    input  logic              spi_hold_n,
    output logic              spi_miso,
    output logic              spi_miso_oe,
    output logic [MEM_AW-1:0] prot_addr,
    input  logic              prot_wr_ok,
    input  logic [5:0]        stat_rd_hi,
    output logic [7:0]        stat_wr_data,
    output logic              stat_wr_en
);

    localparam int ACNT_W = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;

    typedef struct packed {
        phase_e              st;
        logic [2:0]          bits;
        logic [ACNT_W-1:0]   acnt;
        logic                is_rd;
        logic [6:0]          rx;
        logic [7:0]          tx;
        logic [MEM_AW-1:0]   ptr;
        logic                wel;
        logic                mod;
        logic                held;
        logic                sck_prev;
        logic                miso;
        logic                stat_we;
        logic [7:0]          stat_byte;
    } eng_t;

    // synchronised bus pins: {cs, sck, mosi, hold}
    logic [3:0] pins_s;
    logic       cs_s, sck_s, mosi_s, hold_s;

    spi_pin_sync #(
        .W       (4),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (4'b1001)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({spi_cs_n, spi_sck, spi_mosi, spi_hold_n}),
        .dout  (pins_s)
    );

    assign {cs_s, sck_s, mosi_s, hold_s} = pins_s;

    eng_t q, n;
    logic              mem_we;
    logic [MEM_AW-1:0] rd_addr;
    logic [7:0]        mem_rd;
    logic [7:0]        rx_full;
    logic [7:0]        rdsr_byte;
    logic              rise, fall, byte_done;

    spi_mem_array #(
        .AW (MEM_AW),
        .DW (8)
    ) u_array (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .waddr (q.ptr),
        .wdata (rx_full),
        .raddr (rd_addr),
        .rdata (mem_rd)
    );

    assign rx_full   = {q.rx, mosi_s};
    assign rdsr_byte = {stat_rd_hi, q.wel, 1'b0};
    assign rise      = sck_s && !q.sck_prev && !q.held;
    assign fall      = !sck_s && q.sck_prev && !q.held;
    assign byte_done = rise && (q.bits == 3'd7);
    assign rd_addr   = (q.st == ST_ADDR) ? MEM_AW'({q.ptr, rx_full})
                                         : q.ptr + MEM_AW'(1);

    always_comb begin
        n          = q;
        n.stat_we  = 1'b0;
        n.sck_prev = sck_s;
        mem_we     = 1'b0;

        if (cs_s) begin
            n.st   = ST_CMD;
            n.bits = '0;
            n.acnt = '0;
            n.held = 1'b0;
            if (q.mod) begin
                n.wel = 1'b0;
                n.mod = 1'b0;
            end
        end else begin
            if (!q.held && !hold_s && !sck_s) begin
                n.held = 1'b1;
            end else if (q.held && hold_s && !sck_s) begin
                n.held = 1'b0;
            end

            if (rise) begin
                n.rx   = rx_full[6:0];
                n.bits = q.bits + 3'd1;
            end

            if (fall && (q.st == ST_RDATA || q.st == ST_RSTAT)) begin
                n.miso = q.tx[7];
                n.tx   = {q.tx[6:0], 1'b0};
            end

            if (byte_done) begin
                case (q.st)
                    ST_CMD: begin
                        n.st = ST_SKIP;
                        case (rx_full)
                            OP_WR_EN:   n.wel = 1'b1;
                            OP_WR_DIS:  n.wel = 1'b0;
                            OP_RD_STAT: begin
                                n.tx = rdsr_byte;
                                n.st = ST_RSTAT;
                            end
                            OP_WR_STAT: begin
                                if (q.wel) begin
                                    n.st  = ST_WSTAT;
                                    n.mod = 1'b1;
                                end
                            end
                            OP_RD_ARR: begin
                                n.st    = ST_ADDR;
                                n.acnt  = '0;
                                n.is_rd = 1'b1;
                            end
                            OP_WR_ARR: begin
                                if (q.wel) begin
                                    n.st    = ST_ADDR;
                                    n.acnt  = '0;
                                    n.is_rd = 1'b0;
                                    n.mod   = 1'b1;
                                end
                            end
                            default: n.st = ST_SKIP;
                        endcase
                    end
                    ST_ADDR: begin
                        n.ptr  = MEM_AW'({q.ptr, rx_full});
                        n.acnt = q.acnt + ACNT_W'(1);
                        if (q.acnt == ACNT_W'(ADDR_BYTES - 1)) begin
                            n.st = q.is_rd ? ST_RDATA : ST_WDATA;
                            if (q.is_rd) begin
                                n.tx = mem_rd;
                            end
                        end
                    end
                    ST_WDATA: begin
                        mem_we = prot_wr_ok;
                        n.ptr  = q.ptr + MEM_AW'(1);
                    end
                    ST_RDATA: begin
                        n.ptr = q.ptr + MEM_AW'(1);
                        n.tx  = mem_rd;
                    end
                    ST_RSTAT: n.tx = rdsr_byte;
                    ST_WSTAT: begin
                        n.stat_we   = 1'b1;
                        n.stat_byte = rx_full;
                        n.st        = ST_SKIP;
                    end
                    default: n.st = q.st;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= n;
        end
    end

    assign spi_miso     = q.miso;
    assign spi_miso_oe  = (q.st == ST_RDATA || q.st == ST_RSTAT) && !q.held;
    assign prot_addr    = q.ptr;
    assign stat_wr_data = q.stat_byte;
    assign stat_wr_en   = q.stat_we;

    // plain views for the bound checker
    logic              held_w, wel_w, stat_we_w;
    logic [MEM_AW-1:0] ptr_w;
    logic [2:0]        bits_w;
    assign held_w    = q.held;
    assign wel_w     = q.wel;
    assign stat_we_w = q.stat_we;
    assign ptr_w     = q.ptr;
    assign bits_w    = q.bits;

endmodule

// File: rtl/spi_mem_engine_chk.sv
module spi_mem_engine_chk #(
    parameter int AW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cs_s,
    input logic          held,
    input logic          wel,
    input logic          mem_we,
    input logic          stat_we,
    input logic [AW-1:0] ptr,
    input logic [2:0]    bits,
    input logic          miso_oe
);

    AST_DESELECT_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        cs_s |=> !miso_oe); // R10

    AST_STORE_NEEDS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> wel); // R3

    AST_STATUS_NEEDS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        stat_we |-> wel); // R3

    AST_STORE_STEPS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> ptr == AW'($past(ptr) + 1'b1)); // R5

    AST_HOLD_FREEZES_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (held && !cs_s) |=> $stable(bits)); // R8

    AST_HOLD_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        held |-> !miso_oe); // R8

endmodule

bind spi_mem_engine spi_mem_engine_chk #(.AW(MEM_AW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_s    (cs_s),
    .held    (held_w),
    .wel     (wel_w),
    .mem_we  (mem_we),
    .stat_we (stat_we_w),
    .ptr     (ptr_w),
    .bits    (bits_w),
    .miso_oe (spi_miso_oe)
);

// File: tb/spi_mem_engine_tb_top.sv
module spi_mem_engine_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int AW         = 5;
    localparam int DEPTH      = 1 << AW;
    localparam int HALF       = 6;
    localparam int WD_CYCLES  = 190000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cs_n = 1'b1, sck = 1'b0, mosi = 1'b0, hold_n = 1'b1;
    logic          miso, miso_oe;
    logic [AW-1:0] prot_addr;
    logic          prot_wr_ok;
    logic [5:0]    stat_hi = 6'd0;
    logic [7:0]    stat_wr_data;
    logic          stat_wr_en;
    logic          prot_en = 1'b0;

    int n_chk = 0, n_fail = 0;
    int st_cnt = 0;
    logic [7:0] st_last = 8'd0;
    logic [7:0] exp_mem [DEPTH];
    logic       exp_wel = 1'b0;
    logic [7:0] last_rx, last_rx_hi;
    logic       done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign prot_wr_ok = !(prot_en && prot_addr >= AW'(8) && prot_addr <= AW'(11));

    spi_mem_engine #(.MEM_AW(AW)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .spi_cs_n     (cs_n),
        .spi_sck      (sck),
        .spi_mosi     (mosi),
        .spi_hold_n   (hold_n),
        .spi_miso     (miso),
        .spi_miso_oe  (miso_oe),
        .prot_addr    (prot_addr),
        .prot_wr_ok   (prot_wr_ok),
        .stat_rd_hi   (stat_hi),
        .stat_wr_data (stat_wr_data),
        .stat_wr_en   (stat_wr_en)
    );

    always @(posedge clk) begin
        if (stat_wr_en) begin
            st_cnt  <= st_cnt + 1;
            st_last <= stat_wr_data;
        end
    end

    function automatic logic prot_hit(input logic [AW-1:0] a);
        return prot_en && a >= AW'(8) && a <= AW'(11);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic xbit(input logic b, output logic r_lo, output logic r_hi);
        mosi = b;
        wait_clk(HALF);
        r_lo = miso;
        sck = 1'b1;
        wait_clk(HALF);
        r_hi = miso;
        sck = 1'b0;
    endtask

    task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx);
        logic lo, hi;
        for (int i = 7; i >= 0; i--) begin
            xbit(tx[i], lo, hi);
            rx[i]         = lo;
            last_rx_hi[i] = hi;
        end
        last_rx = rx;
    endtask

    task automatic cs_begin();
        cs_n = 1'b0;
        wait_clk(HALF);
    endtask

    task automatic cs_end();
        wait_clk(HALF);
        cs_n = 1'b1;
        wait_clk(2*HALF);
    endtask

    task automatic send_addr(input logic [23:0] a);
        logic [7:0] r;
        xbyte(a[23:16], r);
        xbyte(a[15:8], r);
        xbyte(a[7:0], r);
    endtask

    task automatic simple_op(input logic [7:0] op);
        logic [7:0] r;
        cs_begin();
        xbyte(op, r);
        cs_end();
    endtask

    task automatic wren();
        simple_op(8'h06);
        exp_wel = 1'b1;
    endtask

    task automatic wrdi();
        simple_op(8'h04);
        exp_wel = 1'b0;
    endtask

    task automatic rdsr_chk(input string req);
        logic [7:0] r;
        cs_begin();
        xbyte(8'h05, r);
        xbyte(8'h00, r);
        chk(req, r, {stat_hi, exp_wel, 1'b0});
        xbyte(8'h00, r);
        chk("R12", r, {stat_hi, exp_wel, 1'b0});
        cs_end();
    endtask

    task automatic wr_burst(input logic [23:0] a, input int n,
                            input logic [7:0] base, input logic [7:0] step);
        logic [7:0]    r, d;
        logic [AW-1:0] p;
        cs_begin();
        xbyte(8'h02, r);
        send_addr(a);
        p = a[AW-1:0];
        for (int i = 0; i < n; i++) begin
            d = base + 8'(step * i);
            xbyte(d, r);
            if (exp_wel && !prot_hit(p)) exp_mem[p] = d;
            p = p + AW'(1);
        end
        cs_end();
        exp_wel = 1'b0;
    endtask

    task automatic rd_chk(input logic [23:0] a, input int n, input string req);
        logic [7:0]    r;
        logic [AW-1:0] p;
        cs_begin();
        xbyte(8'h03, r);
        chk("R10", miso_oe, 1'b0);
        send_addr(a);
        chk("R10", miso_oe, 1'b1);
        p = a[AW-1:0];
        for (int i = 0; i < n; i++) begin
            xbyte(8'h00, r);
            chk(req, r, exp_mem[p]);
            if (i == 0) chk("R6", last_rx_hi, last_rx);
            p = p + AW'(1);
        end
        cs_end();
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        logic       lo, hi;
        int         n0;
        for (int i = 0; i < DEPTH; i++) exp_mem[i] = 8'h00;

        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(5);

        // R14: reset state
        chk("R14", miso_oe, 1'b0);
        chk("R14", stat_wr_en, 1'b0);
        rdsr_chk("R14");
        rd_chk(24'h0, 2, "R14");

        // R3: write without latch ignored
        wr_burst(24'h3, 1, 8'hAA, 8'h00);
        rd_chk(24'h3, 1, "R3");

        // R3/R12: latch visible in status
        stat_hi = 6'h2A;
        wren();
        rdsr_chk("R3");

        // R5/R7/R2: burst over the top of the array
        wr_burst(24'hFFFFFE, DEPTH + 2, 8'h05, 8'd37);
        rdsr_chk("R4");
        rd_chk(24'h0, DEPTH, "R5");
        for (int s = 0; s < DEPTH; s++) rd_chk(24'(s), 2, "R7");

        // R4: zero-byte write still clears latch
        wren();
        cs_begin();
        xbyte(8'h02, r);
        send_addr(24'h0);
        cs_end();
        exp_wel = 1'b0;
        rdsr_chk("R4");

        // R3: disable instruction
        wren();
        wrdi();
        rdsr_chk("R3");
        wr_burst(24'h7, 1, 8'h99, 8'h00);
        rd_chk(24'h7, 1, "R3");

        // R9: partial byte discarded
        wren();
        cs_begin();
        xbyte(8'h02, r);
        send_addr(24'h5);
        xbyte(8'h11, r);
        for (int i = 0; i < 4; i++) xbit(1'b1, lo, hi);
        cs_end();
        exp_mem[5] = 8'h11;
        exp_wel    = 1'b0;
        rd_chk(24'h5, 2, "R9");

        // R11: protected window
        prot_en = 1'b1;
        wren();
        wr_burst(24'h6, 8, 8'hC0, 8'h01);
        rd_chk(24'h6, 8, "R11");
        prot_en = 1'b0;

        // R13 / R3: status write
        n0 = st_cnt;
        cs_begin();
        xbyte(8'h01, r);
        xbyte(8'h8C, r);
        cs_end();
        chk("R3", st_cnt, n0);
        wren();
        cs_begin();
        xbyte(8'h01, r);
        xbyte(8'h8C, r);
        xbyte(8'h33, r);
        cs_end();
        exp_wel = 1'b0;
        chk("R13", st_cnt, n0 + 1);
        chk("R13", st_last, 8'h8C);
        rdsr_chk("R4");

        // R1: unknown opcode
        wren();
        cs_begin();
        xbyte(8'hA5, r);
        chk("R1", miso_oe, 1'b0);
        xbyte(8'h02, r);
        send_addr(24'h9);
        xbyte(8'h77, r);
        chk("R1", miso_oe, 1'b0);
        cs_end();
        rdsr_chk("R1");
        rd_chk(24'h9, 1, "R1");
        wrdi();

        // R2: upper address bits ignored
        wren();
        wr_burst(24'h123456, 1, 8'h3C, 8'h00);
        rd_chk(24'h000016, 1, "R2");
        rd_chk(24'hFFFFF6, 1, "R2");

        // R8: hold during write
        wren();
        cs_begin();
        xbyte(8'h02, r);
        send_addr(24'd20);
        for (int b = 7; b >= 5; b--) xbit(r_const(8'h5A, b), lo, hi);
        hold_n = 1'b0;
        wait_clk(HALF);
        for (int k = 0; k < 3; k++) begin
            mosi = ~mosi;
            sck = 1'b1; wait_clk(HALF);
            sck = 1'b0; wait_clk(HALF);
        end
        hold_n = 1'b1;
        wait_clk(HALF);
        for (int b = 4; b >= 0; b--) xbit(r_const(8'h5A, b), lo, hi);
        cs_end();
        exp_mem[20] = 8'h5A;
        exp_wel     = 1'b0;
        rd_chk(24'd20, 1, "R8");

        // R8: hold during read
        cs_begin();
        xbyte(8'h03, r);
        send_addr(24'd20);
        for (int b = 7; b >= 4; b--) begin
            xbit(1'b0, lo, hi);
            r[b] = lo;
        end
        hold_n = 1'b0;
        wait_clk(HALF);
        chk("R8", miso_oe, 1'b0);
        for (int k = 0; k < 3; k++) begin
            sck = 1'b1; wait_clk(HALF);
            sck = 1'b0; wait_clk(HALF);
        end
        hold_n = 1'b1;
        wait_clk(HALF);
        chk("R8", miso_oe, 1'b1);
        for (int b = 3; b >= 0; b--) begin
            xbit(1'b0, lo, hi);
            r[b] = lo;
        end
        chk("R8", r, 8'h5A);
        cs_end();

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    function automatic logic r_const(input logic [7:0] v, input int b);
        return v[b];
    endfunction

endmodule